// File: doc/BRIEF.md
# Touch Controller Serial Command Decoder

This block receives the command byte that a host sends to a touch-screen digitiser over its synchronous serial port. Every rising edge of the serial clock `clk` samples `din` while the active-low select `cs_n` is low. Leading zeros are skipped until a 1 arrives. That 1 is the start bit and the top bit of an 8-bit control word. The remaining seven bits follow most significant first. From the finished word the block decodes four things and holds them in registers: the input channel, the X and Y panel driver enables, the conversion resolution, and the power-down and pen-interrupt settings. In the same cycle it raises a one-cycle `cmd_valid` strobe for the conversion sequencer that follows it.

The control is a four-state machine:

- **IDLE**: entered on reset or whenever `cs_n` is sampled high.
- **HUNT**: skips zeros while looking for the start bit.
- **SHIFT**: collects the seven bits after the start bit.
- **DONE**: ignores `din` after a complete word.

The named transitions are:

- *arm*: IDLE→HUNT, on the first low `cs_n`, when `din` is 0.
- *arm-start*: IDLE→SHIFT, on the first low `cs_n`, when `din` is already 1.
- *start*: HUNT→SHIFT, when a 1 is sampled.
- *complete*: SHIFT→DONE, on the eighth bit.
- *rearm*: DONE→HUNT, when `seq_ready` is high.
- *abort*: any state→IDLE, whenever `cs_n` is high.

IDLE is only ever occupied while `cs_n` is high, so leaving it always marks a falling edge of the select. A reset counts as the select being high.

Top module: `tcd_cmd_decoder`

## Requirements
- R1: While `rst` is high, and after it, until the first complete word, the outputs are `chan_id`=0 (none), `xdrv_en`=0, `ydrv_en`=0, `res_8bit`=0, `pwr_dn`=1, `yneg_on`=1, `pen_irq_en`=1 and `cmd_valid`=0.
- R2: Any edge that samples `cs_n` high abandons a partly received word. No strobe follows, and the decoded outputs do not change.
- R3: After arming, zeros on `din` are skipped. The first 1 sampled is the start bit, which becomes bit 7 of the word.
- R4: The word is received MSB first: bit 7 is the start bit, bits 6:4 are the channel code, bit 3 is Mode1, bit 2 is Mode0, and bits 1:0 are the power-down code. `cmd_valid` is high for exactly the one cycle after the edge that samples bit 0.
- R5: `chan_id` encodes none, X+, Y+, aux3 and aux4 as 0, 1, 2, 3 and 4. Channel code 001 gives X+ with `ydrv_en`=1 and `xdrv_en`=0. Code 101 gives Y+ with `xdrv_en`=1 and `ydrv_en`=0. Code 010 gives aux3 and code 110 gives aux4. Every other code gives none. For aux3, aux4 and none, both driver enables are 0.
- R6: `res_8bit` equals Mode1. Mode0 has no effect on any output.
- R7: Power-down code 00 gives `pwr_dn`=1, `yneg_on`=1 and `pen_irq_en`=1. Code 01 gives `pwr_dn`=1, `yneg_on`=0 and `pen_irq_en`=0. Codes 10 and 11 give `pwr_dn`=0, `yneg_on`=0 and `pen_irq_en`=0.
- R8: All decoded outputs change together, on the edge that samples bit 0. They hold their values until the next complete word.
- R9: After a complete word, `din` is ignored while `cs_n` stays low and `seq_ready` stays low.
- R10: An edge that samples `seq_ready` high in DONE, with `cs_n` low, resumes start-bit hunting from the next edge. Deasserting and then reasserting `cs_n` does the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; `din` is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Active-low select that frames a command |
| din | input | 1 | Serial command data |
| seq_ready | input | 1 | Sequencer ready; re-arms hunting after a word |
| chan_id | output | 3 | Selected channel (0 none, 1 X+, 2 Y+, 3 aux3, 4 aux4) |
| xdrv_en | output | 1 | X panel driver enable |
| ydrv_en | output | 1 | Y panel driver enable |
| res_8bit | output | 1 | 1 selects 8-bit conversion, 0 selects 12-bit |
| pwr_dn | output | 1 | Power down between conversions |
| yneg_on | output | 1 | Y- switch held on while powered down |
| pen_irq_en | output | 1 | Pen interrupt enabled |
| cmd_valid | output | 1 | One-cycle strobe for a newly decoded word |

## Verification
The hardest case to reach from the ports is the DONE state while the select stays low. A complete word must be followed by further 1s on `din` with both `cs_n` and `seq_ready` low. Correct behaviour there is silence: no strobe and unchanged outputs. The stimulus reaches this case in two ways. Directed sequences follow a word with a burst of ones. Random traffic rarely raises `cs_n` or `seq_ready`, so the block spends long stretches in DONE while `din` toggles. A cycle-level model of the framing rules in the bench predicts the strobe and the outputs on every edge. Separate directed cases abort a word midway and place the start bit on the arming edge itself.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_SHIFT,
        ST_DONE
    } tcd_state_e;

    typedef enum logic [2:0] {
        CH_NONE = 3'd0,
        CH_XP   = 3'd1,
        CH_YP   = 3'd2,
        CH_AUX3 = 3'd3,
        CH_AUX4 = 3'd4
    } tcd_chan_e;

    typedef struct packed {
        tcd_chan_e chan;
        logic      xdrv;
        logic      ydrv;
        logic      res8;
        logic      pwr_dn;
        logic      yneg;
        logic      pen;
    } tcd_cfg_t;

    localparam tcd_cfg_t CFG_RESET = '{
        chan:   CH_NONE,
        xdrv:   1'b0,
        ydrv:   1'b0,
        res8:   1'b0,
        pwr_dn: 1'b1,
        yneg:   1'b1,
        pen:    1'b1
    };

endpackage

// File: rtl/tcd_frame_fsm.sv
module tcd_frame_fsm
    import tcd_pkg::*;
#(
    parameter int CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             din,
    input  logic             seq_ready,
    output logic             word_done,
    output logic [CMD_W-1:0] word_val
);
    localparam int CNT_W = $clog2(CMD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_W - 1);

    tcd_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CMD_W-2:0] shreg_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (cs_n) begin
            state_d = ST_IDLE;                              // abort
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = din ? ST_SHIFT : ST_HUNT; // arm-start / arm
                ST_HUNT:  if (din) state_d = ST_SHIFT;      // start
                ST_SHIFT: if (cnt_q == LAST) state_d = ST_DONE; // complete
                ST_DONE:  if (seq_ready) state_d = ST_HUNT; // rearm
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // datapath: bit counter and shift register
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (!cs_n) begin
            if ((state_q == ST_IDLE || state_q == ST_HUNT) && din) begin
                shreg_q <= (CMD_W-1)'(1);
                cnt_q   <= CNT_W'(1);
            end else if (state_q == ST_SHIFT) begin
                shreg_q <= {shreg_q[CMD_W-3:0], din};
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    assign word_done = !cs_n && (state_q == ST_SHIFT) && (cnt_q == LAST);
    assign word_val  = {shreg_q, din};

    assert_abort_idle_R2: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (state_q == ST_IDLE));

    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SHIFT) |-> (cnt_q >= CNT_W'(1) && cnt_q <= LAST));

    assert_done_stays_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE && !cs_n && !seq_ready) |=> (state_q == ST_DONE));

    assert_rearm_hunt_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE && !cs_n && seq_ready) |=> (state_q == ST_HUNT));

endmodule

// File: rtl/tcd_field_decode.sv
module tcd_field_decode
    import tcd_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int CH_W   = 3,
    parameter int MODE_W = 2,
    parameter int PD_W   = 2
) (
    input  logic [CMD_W-1:0] word,
    output tcd_cfg_t         cfg
);
    localparam int PD_LSB = 0;
    localparam int MD_LSB = PD_LSB + PD_W;
    localparam int CH_LSB = MD_LSB + MODE_W;
    localparam int MODE1  = MD_LSB + MODE_W - 1;

    logic [CH_W-1:0] ch_code;
    logic [PD_W-1:0] pd_code;
    logic            unused_bits;

    assign ch_code     = word[CH_LSB +: CH_W];
    assign pd_code     = word[PD_LSB +: PD_W];
    assign unused_bits = ^{word[CMD_W-1], word[MD_LSB +: MODE_W-1]};

    always_comb begin
        cfg = CFG_RESET;
        cfg.xdrv = 1'b0;
        cfg.ydrv = 1'b0;
        case (ch_code)
            3'b001:  begin cfg.chan = CH_XP; cfg.ydrv = 1'b1; end
            3'b101:  begin cfg.chan = CH_YP; cfg.xdrv = 1'b1; end
            3'b010:  cfg.chan = CH_AUX3;
            3'b110:  cfg.chan = CH_AUX4;
            default: cfg.chan = CH_NONE;
        endcase
        cfg.res8 = word[MODE1];
        case (pd_code)
            2'b00:   begin cfg.pwr_dn = 1'b1; cfg.yneg = 1'b1; cfg.pen = 1'b1; end
            2'b01:   begin cfg.pwr_dn = 1'b1; cfg.yneg = 1'b0; cfg.pen = 1'b0; end
            default: begin cfg.pwr_dn = 1'b0; cfg.yneg = 1'b0; cfg.pen = 1'b0; end
        endcase
    end

endmodule

// File: rtl/tcd_cfg_latch.sv
module tcd_cfg_latch
    import tcd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  tcd_cfg_t cfg_in,
    output tcd_cfg_t cfg_q,
    output logic     valid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= CFG_RESET;
            valid_q <= 1'b0;
        end else begin
            valid_q <= load;
            if (load) cfg_q <= cfg_in;
        end
    end

    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> $stable(cfg_q));

    assert_drv_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(cfg_q.xdrv && cfg_q.ydrv));

    assert_pen_needs_pd_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_q.pen |-> (cfg_q.pwr_dn && cfg_q.yneg));

endmodule

// File: rtl/tcd_cmd_decoder.sv
module tcd_cmd_decoder
    import tcd_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int CH_W   = 3,
    parameter int MODE_W = 2,
    parameter int PD_W   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       din,
    input  logic       seq_ready,
    output logic [2:0] chan_id,
    output logic       xdrv_en,
    output logic       ydrv_en,
    output logic       res_8bit,
    output logic       pwr_dn,
    output logic       yneg_on,
    output logic       pen_irq_en,
    output logic       cmd_valid
);
    logic             word_done;
    logic [CMD_W-1:0] word_val;
    tcd_cfg_t         cfg_dec, cfg_q;

    tcd_frame_fsm #(.CMD_W(CMD_W)) frame_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .din(din), .seq_ready(seq_ready),
        .word_done(word_done), .word_val(word_val)
    );

    tcd_field_decode #(.CMD_W(CMD_W), .CH_W(CH_W), .MODE_W(MODE_W), .PD_W(PD_W)) dec_i (
        .word(word_val), .cfg(cfg_dec)
    );

    tcd_cfg_latch latch_i (
        .clk(clk), .rst(rst), .load(word_done), .cfg_in(cfg_dec),
        .cfg_q(cfg_q), .valid_q(cmd_valid)
    );

    assign chan_id    = cfg_q.chan;
    assign xdrv_en    = cfg_q.xdrv;
    assign ydrv_en    = cfg_q.ydrv;
    assign res_8bit   = cfg_q.res8;
    assign pwr_dn     = cfg_q.pwr_dn;
    assign yneg_on    = cfg_q.yneg;
    assign pen_irq_en = cfg_q.pen;

    assert_valid_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !$past(cs_n));

endmodule

// File: tb/tcd_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module tcd_cmd_decoder_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, din = 1'b0, seq_ready = 1'b0;
    logic [2:0] chan_id;
    logic xdrv_en, ydrv_en, res_8bit, pwr_dn, yneg_on, pen_irq_en, cmd_valid;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    tcd_cmd_decoder dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .din(din), .seq_ready(seq_ready),
        .chan_id(chan_id), .xdrv_en(xdrv_en), .ydrv_en(ydrv_en), .res_8bit(res_8bit),
        .pwr_dn(pwr_dn), .yneg_on(yneg_on), .pen_irq_en(pen_irq_en), .cmd_valid(cmd_valid)
    );

    localparam logic [8:0] RESET_VEC = {3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

    // bench-side model of the framing rules
    int         m_st = 0;     // 0 idle, 1 hunt, 2 shift, 3 done
    int         m_cnt = 0;
    logic [7:0] m_word = '0;
    logic [8:0] exp_out = RESET_VEC;
    logic       exp_v = 1'b0;

    function automatic logic [8:0] exp_fields(input logic [7:0] w);
        logic [2:0] ch;
        logic x, y, p, yn, pe;
        ch = 3'd0; x = 1'b0; y = 1'b0;
        case (w[6:4])
            3'b001:  begin ch = 3'd1; y = 1'b1; end
            3'b101:  begin ch = 3'd2; x = 1'b1; end
            3'b010:  ch = 3'd3;
            3'b110:  ch = 3'd4;
            default: ch = 3'd0;
        endcase
        case (w[1:0])
            2'b00:   begin p = 1'b1; yn = 1'b1; pe = 1'b1; end
            2'b01:   begin p = 1'b1; yn = 1'b0; pe = 1'b0; end
            default: begin p = 1'b0; yn = 1'b0; pe = 1'b0; end
        endcase
        return {ch, x, y, w[3], p, yn, pe};
    endfunction

    function automatic logic [8:0] got_vec();
        return {chan_id, xdrv_en, ydrv_en, res_8bit, pwr_dn, yneg_on, pen_irq_en};
    endfunction

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic model_step(input logic c, input logic d, input logic r);
        exp_v = 1'b0;
        if (c) m_st = 0;
        else begin
            case (m_st)
                0: begin
                    if (d) begin m_st = 2; m_word = 8'h01; m_cnt = 1; end
                    else m_st = 1;
                end
                1: if (d) begin m_st = 2; m_word = 8'h01; m_cnt = 1; end
                2: begin
                    m_word = {m_word[6:0], d};
                    m_cnt++;
                    if (m_cnt == 8) begin
                        exp_out = exp_fields(m_word);
                        exp_v = 1'b1;
                        m_st = 3;
                    end
                end
                default: if (r) m_st = 1;
            endcase
        end
    endtask

    task automatic tick(input logic c, input logic d, input logic r, input string tag);
        @(negedge clk);
        cs_n = c; din = d; seq_ready = r;
        @(posedge clk);
        model_step(c, d, r);
        #1;
        check(tag, {cmd_valid, got_vec()}, {exp_v, exp_out});
    endtask

    task automatic send_word(input logic [7:0] w, input string tag);
        for (int i = 7; i >= 0; i--) tick(1'b0, w[i], 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] w;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", {cmd_valid, got_vec()}, {1'b0, RESET_VEC});
        @(negedge clk);
        rst = 1'b0;
        tick(1'b1, 1'b0, 1'b0, "R1 idle");
        check("R1 after reset", {cmd_valid, got_vec()}, {1'b0, RESET_VEC});

        // R3: leading zeros, then X+ word
        tick(1'b0, 1'b0, 1'b0, "R3");
        tick(1'b0, 1'b0, 1'b0, "R3");
        tick(1'b0, 1'b0, 1'b0, "R3");
        send_word(8'b1_001_0_0_00, "R3 R4");
        check("R5 X+ drivers", {7'd0, chan_id, ydrv_en, xdrv_en} , {7'd0, 3'd1, 1'b1, 1'b0});

        // all channel codes, modes and power-down codes
        for (int k = 0; k < 32; k++) begin
            w = {1'b1, k[2:0], k[3], k[2], k[4:3]};
            tick(1'b1, 1'b0, 1'b0, "R2");
            send_word(w, "R5 R6 R7");
        end

        // R6: Mode0 alone changes nothing
        tick(1'b1, 1'b0, 1'b0, "R6");
        send_word(8'b1_101_1_0_01, "R6");
        tick(1'b1, 1'b0, 1'b0, "R6");
        send_word(8'b1_101_1_1_01, "R6 mode0");
        check("R6 Y+ 8bit", {1'b0, got_vec()}, {1'b0, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0});

        // R7: unused code 10 behaves like 11
        tick(1'b1, 1'b0, 1'b0, "R7");
        send_word(8'b1_010_0_0_10, "R7 code10");
        check("R7 code10", {1'b0, got_vec()}, {1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});

        // R9: ones after a complete word are ignored
        for (int i = 0; i < 12; i++) tick(1'b0, 1'b1, 1'b0, "R9 ignore");

        // R10: sequencer ready re-arms
        tick(1'b0, 1'b0, 1'b1, "R10 ready");
        tick(1'b0, 1'b0, 1'b0, "R10");
        send_word(8'b1_110_0_0_00, "R10 rearm");
        check("R10 aux4", {cmd_valid, got_vec()}, {1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1});

        // R2/R8: abort mid-word
        tick(1'b1, 1'b0, 1'b0, "R2");
        tick(1'b0, 1'b1, 1'b0, "R2 start on arm edge");
        tick(1'b0, 1'b0, 1'b0, "R2");
        tick(1'b0, 1'b1, 1'b0, "R2");
        tick(1'b1, 1'b1, 1'b0, "R2 abort");
        check("R8 held after abort", {cmd_valid, got_vec()}, {1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1});
        send_word(8'b1_001_1_1_11, "R8 fresh");

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            tick(($urandom % 24) == 0, 1'($urandom), ($urandom % 20) == 0, "R2 R3 R4 R8 R9 R10 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule